// File: doc/BRIEF.md
# Master/Slave Delay Tap Calculator

This block is the digital control behind a delay-compensation scheme built from identical delay elements. A master line is swept one tap per clock. A behavioural phase detector reports when the edge delayed by the probed number of elements lines up with the next clock edge. The first tap at which that happens is the number of elements in one full clock period.

That per-cycle count is then scaled by programmable 7-bit fractions, in steps of 1/128. The results are the tap selects of the slave lines: one for the clock/write-strobe shift, one for the write-strobe output shift, and one independent line per read-strobe lane. Master and slave elements are identical, so a tap count gives the same delay on either line.

The block only computes tap indices. It generates no clock and models no analog delay cell. The slave outputs change only when a measurement completes, and they keep their values until the next good measurement.

Top module: `dly_tap_calc`

## Requirements
- R1: After a synchronous active-high reset, `probe_tap`, `cycle_taps` and every slave tap are 0, and `busy`, `locked` and `meas_err` are 0.
- R2: A `meas_start` pulse seen while idle starts a sweep. On the next edge `busy` goes high and `probe_tap` is 1. On each later edge `probe_tap` rises by one until a hit or the line limit is reached.
- R3: When `probe_hit` is high with `probe_tap` = k, that k becomes the cycle count. It appears on `cycle_taps` one edge later, on the same edge where `busy` falls.
- R4: Each slave tap equals floor(cycle_count × fraction / 128), a right shift by 7 of the product. The slaves are: `tap_clk` from `frac_clk`, `tap_wdqs` from `frac_wdqs`, and read lane i on `tap_rd[TAP_W*i +: TAP_W]` from `frac_rd[7*i +: 7]`. All take the fraction values present on the completing edge.
- R5: Between completions, `cycle_taps` and all slave taps hold. Fraction changes have no effect until the next measurement completes.
- R6: `locked` stays 0 from reset until the first successful measurement completes. After that it stays 1, even across a failed measurement.
- R7: If no hit occurs up to and including `probe_tap` = MAX_TAPS, the sweep stops and `meas_err` goes high. `cycle_taps` and the slave taps are left unchanged. `meas_err` clears when the next measurement is accepted.
- R8: `meas_start` while `busy` is ignored: the sweep keeps counting and does not restart at 1.
- R9: A fraction of 0 gives tap 0. A fraction of 127 gives floor(count × 127 / 128). A hit at exactly MAX_TAPS is a success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_start | input | 1 | Pulse that requests a master measurement |
| probe_hit | input | 1 | Phase detector: the edge delayed by `probe_tap` elements meets the next clock edge |
| frac_clk | input | 7 | Fraction for the clock/write-strobe shift |
| frac_wdqs | input | 7 | Fraction for the write-strobe output shift |
| frac_rd | input | 7*LANES | Read-capture fraction, one per lane |
| probe_tap | output | TAP_W | Master tap currently probed (0 when idle) |
| busy | output | 1 | Measurement in progress |
| cycle_taps | output | TAP_W | Last accepted per-cycle element count |
| tap_clk | output | TAP_W | Clock/write-strobe slave tap |
| tap_wdqs | output | TAP_W | Write-strobe output slave tap |
| tap_rd | output | TAP_W*LANES | Read-capture slave taps, one per lane |
| locked | output | 1 | At least one measurement has succeeded |
| meas_err | output | 1 | Last measurement found no full cycle |

## Verification
A sweep that hits at tap T delivers `cycle_taps`, all slave taps and `locked` T+1 edges after the edge that accepted `meas_start`. A sweep that fails raises `meas_err` MAX_TAPS edges after that edge, and `probe_tap` advances on every edge in between. The bench drives inputs on falling edges and advances its behavioural model on each rising edge. It compares every output 1 ns after that rising edge, so each result is checked in the exact cycle it is due. Directed checks at idle points add hand-computed tap values, hold behaviour and ignored-start behaviour.

// File: rtl/dly_tap_pkg.sv
package dly_tap_pkg;

    localparam int FRAC_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_COMMIT = 2'd2
    } sweep_state_t;

    typedef struct packed {
        logic load;
        logic fail;
    } sweep_evt_t;

endpackage

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl
    import dly_tap_pkg::*;
#(
    parameter int TAP_W    = 8,
    parameter int MAX_TAPS = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_start,
    input  logic             probe_hit,
    output logic [TAP_W-1:0] probe_tap,
    output logic [TAP_W-1:0] found_taps,
    output logic [TAP_W-1:0] cycle_taps,
    output logic             busy,
    output logic             locked,
    output logic             meas_err,
    output sweep_evt_t       evt
);

    localparam logic [TAP_W-1:0] LIMIT = TAP_W'(MAX_TAPS);

    sweep_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            probe_tap  <= '0;
            found_taps <= '0;
            cycle_taps <= '0;
            locked     <= 1'b0;
            meas_err   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (meas_start) begin
                        state     <= ST_SWEEP;
                        probe_tap <= TAP_W'(1);
                        meas_err  <= 1'b0;
                    end
                end
                ST_SWEEP: begin
                    if (probe_hit) begin
                        found_taps <= probe_tap;
                        probe_tap  <= '0;
                        state      <= ST_COMMIT;
                    end else if (probe_tap == LIMIT) begin
                        meas_err  <= 1'b1;
                        probe_tap <= '0;
                        state     <= ST_IDLE;
                    end else begin
                        probe_tap <= probe_tap + TAP_W'(1);
                    end
                end
                ST_COMMIT: begin
                    cycle_taps <= found_taps;
                    locked     <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign evt.load = (state == ST_COMMIT);
    assign evt.fail = (state == ST_SWEEP) && !probe_hit && (probe_tap == LIMIT);

    // R2: sweep advances one tap per edge while no hit and below the limit
    a_r2_probe_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SWEEP && !probe_hit && probe_tap != LIMIT)
        |=> probe_tap == $past(probe_tap) + TAP_W'(1));

    // R6: lock never drops once set
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R5: cycle count changes only on a commit edge
    a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_COMMIT) |=> $stable(cycle_taps));

    // R8: a start request during a sweep never restarts the probe at 1
    a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && meas_start) |=> probe_tap != TAP_W'(1));

    // R7: a failed sweep leaves the accepted count untouched
    a_r7_fail_keeps_count: assert property (@(posedge clk) disable iff (rst)
        $rose(meas_err) |-> $stable(cycle_taps));

endmodule

// File: rtl/dly_slave_scale.sv
module dly_slave_scale
    import dly_tap_pkg::*;
#(
    parameter int TAP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TAP_W-1:0]  count,
    input  logic [FRAC_W-1:0] frac,
    output logic [TAP_W-1:0]  tap
);

    localparam int PW = TAP_W + FRAC_W;

    logic [PW-1:0] product;

    assign product = PW'(count) * PW'(frac);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= '0;
        end else if (load) begin
            tap <= product[PW-1:FRAC_W];
        end
    end

    // R5: slave tap holds whenever no load is presented
    a_r5_slave_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(tap));

endmodule

// File: rtl/dly_tap_calc.sv
module dly_tap_calc
    import dly_tap_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int TAP_W    = 8,
    parameter int MAX_TAPS = 200
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    meas_start,
    input  logic                    probe_hit,
    input  logic [FRAC_W-1:0]       frac_clk,
    input  logic [FRAC_W-1:0]       frac_wdqs,
    input  logic [FRAC_W*LANES-1:0] frac_rd,
    output logic [TAP_W-1:0]        probe_tap,
    output logic                    busy,
    output logic [TAP_W-1:0]        cycle_taps,
    output logic [TAP_W-1:0]        tap_clk,
    output logic [TAP_W-1:0]        tap_wdqs,
    output logic [TAP_W*LANES-1:0]  tap_rd,
    output logic                    locked,
    output logic                    meas_err
);

    localparam int NSLV = LANES + 2;

    logic [TAP_W-1:0]       found_taps;
    sweep_evt_t             evt;
    logic [FRAC_W*NSLV-1:0] all_frac;
    logic [TAP_W*NSLV-1:0]  all_tap;

    dly_sweep_ctrl #(.TAP_W(TAP_W), .MAX_TAPS(MAX_TAPS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .meas_start (meas_start),
        .probe_hit  (probe_hit),
        .probe_tap  (probe_tap),
        .found_taps (found_taps),
        .cycle_taps (cycle_taps),
        .busy       (busy),
        .locked     (locked),
        .meas_err   (meas_err),
        .evt        (evt)
    );

    // slave 0: clock shift, slave 1: write strobe, slaves 2..: read lanes
    assign all_frac = {frac_rd, frac_wdqs, frac_clk};

    for (genvar s = 0; s < NSLV; s++) begin : g_slave
        dly_slave_scale #(.TAP_W(TAP_W)) u_slave (
            .clk   (clk),
            .rst   (rst),
            .load  (evt.load),
            .count (found_taps),
            .frac  (all_frac[FRAC_W*s +: FRAC_W]),
            .tap   (all_tap[TAP_W*s +: TAP_W])
        );

        // R4: a fraction below one never yields more taps than the cycle count
        a_r4_tap_bound: assert property (@(posedge clk) disable iff (rst)
            all_tap[TAP_W*s +: TAP_W] <= cycle_taps);
    end

    assign tap_clk  = all_tap[0 +: TAP_W];
    assign tap_wdqs = all_tap[TAP_W +: TAP_W];
    assign tap_rd   = all_tap[TAP_W*2 +: TAP_W*LANES];

    // R7: a failing sweep never commits new slave values on the next edge
    a_r7_fail_no_load: assert property (@(posedge clk) disable iff (rst)
        evt.fail |=> !evt.load);

endmodule

// File: tb/dly_tap_calc_bench.sv
module dly_tap_calc_bench;

    localparam int LANES    = 4;
    localparam int TAP_W    = 8;
    localparam int MAX_TAPS = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic meas_start = 1'b0;
    logic probe_hit;
    logic [6:0] frac_clk = '0;
    logic [6:0] frac_wdqs = '0;
    logic [7*LANES-1:0] frac_rd = '0;
    logic [TAP_W-1:0] probe_tap, cycle_taps, tap_clk, tap_wdqs;
    logic [TAP_W*LANES-1:0] tap_rd;
    logic busy, locked, meas_err;

    int target = 0;
    int n_checks = 0;
    int n_errors = 0;
    int n_cycles = 0;
    bit finished = 0;

    // behavioural model state
    int m_phase = 0;   // 0 idle, 1 sweeping, 2 committing
    int m_probe = 0;
    int m_found = 0;
    int m_cycle = 0;
    int m_lock = 0;
    int m_err = 0;
    int m_tap[LANES+2];

    always #2 clk = ~clk;

    assign probe_hit = (int'(probe_tap) == target);

    dly_tap_calc #(.LANES(LANES), .TAP_W(TAP_W), .MAX_TAPS(MAX_TAPS)) u_dly_tap_calc (
        .clk(clk), .rst(rst), .meas_start(meas_start), .probe_hit(probe_hit),
        .frac_clk(frac_clk), .frac_wdqs(frac_wdqs), .frac_rd(frac_rd),
        .probe_tap(probe_tap), .busy(busy), .cycle_taps(cycle_taps),
        .tap_clk(tap_clk), .tap_wdqs(tap_wdqs), .tap_rd(tap_rd),
        .locked(locked), .meas_err(meas_err)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int frac_of(int s);
        if (s == 0) return int'(frac_clk);
        if (s == 1) return int'(frac_wdqs);
        return int'(frac_rd[7*(s-2) +: 7]);
    endfunction

    function automatic int dut_tap(int s);
        if (s == 0) return int'(tap_clk);
        if (s == 1) return int'(tap_wdqs);
        return int'(tap_rd[TAP_W*(s-2) +: TAP_W]);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // model advance and per-clock comparison
    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_probe = 0; m_found = 0; m_cycle = 0; m_lock = 0; m_err = 0;
            for (int s = 0; s < LANES+2; s++) m_tap[s] = 0;
        end else begin
            case (m_phase)
                0: if (meas_start) begin m_phase = 1; m_probe = 1; m_err = 0; end
                1: begin
                    if (m_probe == target) begin
                        m_found = m_probe; m_probe = 0; m_phase = 2;
                    end else if (m_probe == MAX_TAPS) begin
                        m_err = 1; m_probe = 0; m_phase = 0;
                    end else begin
                        m_probe = m_probe + 1;
                    end
                end
                default: begin
                    m_cycle = m_found;
                    for (int s = 0; s < LANES+2; s++) m_tap[s] = (m_found * frac_of(s)) / 128;
                    m_lock = 1;
                    m_phase = 0;
                end
            endcase
        end
        #1;
        check("R2", "probe_tap", int'(probe_tap), m_probe);
        check("R2", "busy", int'(busy), (m_phase != 0) ? 1 : 0);
        check("R3", "cycle_taps", int'(cycle_taps), m_cycle);
        for (int s = 0; s < LANES+2; s++) check("R4", "slave tap", dut_tap(s), m_tap[s]);
        check("R6", "locked", int'(locked), m_lock);
        check("R7", "meas_err", int'(meas_err), m_err);
    end

    // watchdog
    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 20000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_cycles, 20000);
            finish_run();
        end
    end

    task automatic run_meas(int t);
        @(negedge clk);
        target = t;
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "probe_tap", int'(probe_tap), 0);
        check("R1", "cycle_taps", int'(cycle_taps), 0);
        check("R1", "tap_clk", int'(tap_clk), 0);
        check("R1", "tap_rd", int'(tap_rd), 0);
        check("R1", "busy", int'(busy), 0);
        check("R1", "locked", int'(locked), 0);
        check("R1", "meas_err", int'(meas_err), 0);
        rst = 1'b0;

        // R4 / R9: fractions with T=100
        frac_clk  = 7'd32;
        frac_wdqs = 7'd96;
        frac_rd   = {7'd1, 7'd64, 7'd127, 7'd0};
        run_meas(100);
        check("R3", "cycle_taps T=100", int'(cycle_taps), 100);
        check("R4", "tap_clk 100*32/128", int'(tap_clk), 25);
        check("R4", "tap_wdqs 100*96/128", int'(tap_wdqs), 75);
        check("R9", "lane0 frac 0", int'(tap_rd[0 +: 8]), 0);
        check("R9", "lane1 frac 127", int'(tap_rd[8 +: 8]), 99);
        check("R4", "lane2 frac 64", int'(tap_rd[16 +: 8]), 50);
        check("R4", "lane3 frac 1", int'(tap_rd[24 +: 8]), 0);
        check("R6", "locked after success", int'(locked), 1);

        // R5: fraction change while idle has no effect
        frac_clk = 7'd127;
        frac_rd[0 +: 7] = 7'd100;
        repeat (5) @(negedge clk);
        check("R5", "tap_clk held", int'(tap_clk), 25);
        check("R5", "lane0 held", int'(tap_rd[0 +: 8]), 0);

        // R8: start during a sweep is ignored
        target = 30;
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        repeat (4) @(negedge clk);
        begin
            int p;
            p = int'(probe_tap);
            meas_start = 1'b1;
            @(negedge clk);
            meas_start = 1'b0;
            check("R8", "probe_tap after busy start", int'(probe_tap), p + 1);
        end
        while (busy) @(negedge clk);
        check("R3", "cycle_taps T=30", int'(cycle_taps), 30);
        check("R9", "tap_clk 30*127/128", int'(tap_clk), 29);
        check("R4", "lane0 30*100/128", int'(tap_rd[0 +: 8]), 23);

        // R9: hit exactly at the line limit succeeds
        run_meas(MAX_TAPS);
        check("R9", "cycle_taps at limit", int'(cycle_taps), MAX_TAPS);
        check("R7", "no error at limit", int'(meas_err), 0);

        // R7: no hit within the line
        run_meas(MAX_TAPS + 50);
        check("R7", "meas_err on miss", int'(meas_err), 1);
        check("R7", "cycle_taps kept", int'(cycle_taps), MAX_TAPS);
        check("R7", "tap_clk kept", int'(tap_clk), 198);
        check("R6", "locked kept after miss", int'(locked), 1);

        // minimum count, error cleared
        frac_wdqs = 7'd127;
        run_meas(1);
        check("R7", "meas_err cleared", int'(meas_err), 0);
        check("R3", "cycle_taps T=1", int'(cycle_taps), 1);
        check("R9", "tap_wdqs 1*127/128", int'(tap_wdqs), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule